// File: doc/BRIEF.md
# Three-Bus Register Datapath

This block is the register side of a small microcoded processor. It keeps seven 8-bit registers: a scratch register, top-of-stack, stack pointer, instruction byte buffer, program counter, data address and data value. In each cycle one encoded field in the 32-bit control word picks which register drives the A operand bus, and a second field picks the B operand bus. Both buses feed an external ALU, whose combinational result comes back as the C bus. A one-hot group of load enables then chooses which registers capture that result at the next rising clock edge.

Two registers have special sources. The instruction byte buffer loads only from the instruction ROM read port. The data register loads from either the C bus or the data RAM read port, as one control bit selects. The program counter addresses the instruction ROM. The data address register, plus a region bit and a configurable region base, forms the data RAM address. The data register value is the RAM write data, and a control bit strobes the write. The RAM, the ROM, the ALU and the microcode sequencer are all outside this block.

Top module: `tribus_datapath`

## Requirements
- R1: While `rst_n` is low, every register reads as 0x00. `rst_n` clears the registers asynchronously. After `rst_n` rises, loads resume once two clock edges of synchronised release have passed.
- R2: `ctrl_word[10:8]` selects the A bus source: 1 scratch, 2 top-of-stack, 3 stack pointer, 4 instruction byte, 5 program counter, 6 data address, 7 data value.
- R3: `ctrl_word[13:11]` selects the B bus source with the same codes, independently of the A field.
- R4: Source code 0 drives 0x00 onto its bus.
- R5: Load enables sit at `ctrl_word[14+k]`, where k is the register's source code minus one (14 scratch up to 20 data value). An enabled register captures its source at the rising edge. A register whose enable is clear keeps its value.
- R6: The instruction byte register loads `rom_rdata` and ignores the C bus.
- R7: With `ctrl_word[21]`=0 the data value register loads the C bus. With `ctrl_word[21]`=1 it loads `ram_rdata`.
- R8: `ram_we` follows `ctrl_word[22]`, and `ram_wdata` always shows the data value register.
- R9: With `ctrl_word[31]`=0, `ram_addr` equals the data address register. With `ctrl_word[31]`=1, it equals that register plus `stack_base`, modulo 256.
- R10: `rom_addr` always shows the program counter.
- R11: A register that drives a bus, or the RAM write data, in the same cycle that it loads shows its old value during that cycle. The new value appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Microinstruction control word |
| alu_result | input | 8 | C bus, the ALU result |
| ram_rdata | input | 8 | Data RAM read data |
| rom_rdata | input | 8 | Instruction ROM read data |
| stack_base | input | 8 | Offset added to the address in the stack region |
| a_bus | output | 8 | A operand bus |
| b_bus | output | 8 | B operand bus |
| ram_addr | output | 8 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data |
| ram_we | output | 1 | Data RAM write strobe |
| rom_addr | output | 8 | Instruction ROM address |

## Verification
Two of this block's functions can fall in the same cycle: a register can drive a bus while it is also loading, and the data value register can feed a RAM write while it reloads from the RAM. The bench provokes both. In one cycle it selects the scratch register onto both buses and also enables its load. In another it raises the write strobe together with a RAM-sourced load of the data value register. It judges both by checking that the buses and write data show the old value within the cycle and the new value in the next one.

// File: rtl/tribus_pkg.sv
package tribus_pkg;
  localparam int DW     = 8;
  localparam int NREG   = 7;
  localparam int SELW   = 3;
  localparam int CTRL_W = 32;

  localparam int A_LSB       = 8;
  localparam int B_LSB       = 11;
  localparam int LD_LSB      = 14;
  localparam int MDR_SRC_BIT = 21;
  localparam int WR_BIT      = 22;
  localparam int STK_BIT     = 31;

  typedef enum logic [2:0] {
    IX_SCR = 3'd0,
    IX_TOS = 3'd1,
    IX_SP  = 3'd2,
    IX_IB  = 3'd3,
    IX_PC  = 3'd4,
    IX_DA  = 3'd5,
    IX_DV  = 3'd6
  } reg_ix_e;
endpackage

// File: rtl/tribus_rst_sync.sv
module tribus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tribus_reg.sv
module tribus_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  // R5: a cleared enable keeps the value
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
  // R5: an enabled load captures the source present at the edge
  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> q == $past(d));
endmodule

// File: rtl/tribus_bus_mux.sv
module tribus_bus_mux
  import tribus_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [SELW-1:0]         sel,
  output logic [DW-1:0]           bus
);
  always_comb begin
    bus = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SELW'(i + 1)) bus = regs[i];
    end
  end
endmodule

// File: rtl/tribus_addr_gen.sv
module tribus_addr_gen #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] offset,
  input  logic          stack_sel,
  output logic [AW-1:0] phys_addr
);
  always_comb begin
    phys_addr = base_addr;
    if (stack_sel) phys_addr = base_addr + offset;
  end
endmodule

// File: rtl/tribus_datapath.sv
module tribus_datapath
  import tribus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [DW-1:0]     alu_result,
  input  logic [DW-1:0]     ram_rdata,
  input  logic [DW-1:0]     rom_rdata,
  input  logic [DW-1:0]     stack_base,
  output logic [DW-1:0]     a_bus,
  output logic [DW-1:0]     b_bus,
  output logic [DW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic [DW-1:0]     rom_addr
);
  logic                   rst_sync_n;
  logic [NREG-1:0][DW-1:0] reg_q;
  logic [NREG-1:0][DW-1:0] reg_d;
  logic                   unused_ctrl;

  assign unused_ctrl = ^{ctrl_word[7:0], ctrl_word[30:23]};

  tribus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) reg_d[i] = alu_result;
    reg_d[int'(IX_IB)] = rom_rdata;
    reg_d[int'(IX_DV)] = ctrl_word[MDR_SRC_BIT] ? ram_rdata : alu_result;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    tribus_reg #(.W(DW)) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (ctrl_word[LD_LSB+g]),
      .d     (reg_d[g]),
      .q     (reg_q[g])
    );
  end

  tribus_bus_mux u_amux (
    .regs (reg_q),
    .sel  (ctrl_word[A_LSB +: SELW]),
    .bus  (a_bus)
  );

  tribus_bus_mux u_bmux (
    .regs (reg_q),
    .sel  (ctrl_word[B_LSB +: SELW]),
    .bus  (b_bus)
  );

  tribus_addr_gen #(.AW(DW)) u_addr (
    .base_addr (reg_q[int'(IX_DA)]),
    .offset    (stack_base),
    .stack_sel (ctrl_word[STK_BIT]),
    .phys_addr (ram_addr)
  );

  assign ram_wdata = reg_q[int'(IX_DV)];
  assign ram_we    = ctrl_word[WR_BIT];
  assign rom_addr  = reg_q[int'(IX_PC)];

  // R7: a RAM-sourced load of the data value register
  assert_dv_ram_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_word[LD_LSB+int'(IX_DV)] && ctrl_word[MDR_SRC_BIT])
      |=> reg_q[int'(IX_DV)] == $past(ram_rdata));
  // R4: code zero yields an idle bus
  assert_zero_src_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_word[A_LSB +: SELW] == '0) |-> a_bus == '0);
  // R9: stack region address offset
  assert_stack_addr_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_word[STK_BIT] |-> ram_addr == DW'(reg_q[int'(IX_DA)] + stack_base));
endmodule

// File: tb/tribus_datapath_tb.sv
module tribus_datapath_tb_top;
  typedef enum int {K_A, K_B, K_ADDR, K_WD, K_WE, K_ROM} kind_e;
  typedef struct {
    int        req;
    kind_e     kind;
    logic [7:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [7:0]  alu_result = '0, ram_rdata = '0, rom_rdata = '0, stack_base = '0;
  logic [7:0]  a_bus, b_bus, ram_addr, ram_wdata, rom_addr;
  logic        ram_we;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  item_t sb_q[$];
  event  obs_ev;
  logic [7:0] m [7];

  always #2 clk = ~clk;

  tribus_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .alu_result(alu_result),
    .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .stack_base(stack_base),
    .a_bus(a_bus), .b_bus(b_bus), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .rom_addr(rom_addr)
  );

  // monitor: pops expectations and compares them with the ports
  always @(obs_ev) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_A:    act = a_bus;
        K_B:    act = b_bus;
        K_ADDR: act = ram_addr;
        K_WD:   act = ram_wdata;
        K_WE:   act = {7'd0, ram_we};
        default: act = rom_addr;
      endcase
      n_tests++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL R%0d kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] mk(input int a, input int b, input logic [6:0] ld,
                                     input bit dv_ram, input bit wr, input bit stk);
    logic [31:0] c;
    c = '0;
    c[10:8] = 3'(a); c[13:11] = 3'(b); c[20:14] = ld;
    c[21] = dv_ram; c[22] = wr; c[31] = stk;
    return c;
  endfunction

  task automatic step(input logic [31:0] c, input logic [7:0] alu, input logic [7:0] rd,
                      input logic [7:0] ro);
    @(negedge clk);
    ctrl_word = c; alu_result = alu; ram_rdata = rd; rom_rdata = ro;
    #1;
  endtask

  task automatic push(input int req, input kind_e k, input logic [7:0] e);
    item_t it;
    it.req = req; it.kind = k; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic check();
    ->obs_ev;
    wait (sb_q.size() == 0);
  endtask

  // read register idx on both buses, without loading anything
  task automatic read_reg(input int idx, input int req);
    step(mk(idx + 1, idx + 1, 7'd0, 0, 0, 0), 8'hC3, 8'h3C, 8'h5A);
    push(req, K_A, m[idx]);
    push(req, K_B, m[idx]);
    check();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R0 watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every register is zero after reset
    for (int i = 0; i < 7; i++) read_reg(i, 1);

    // R5/R6/R7: load each register in turn from its own source
    step(mk(0, 0, 7'b0000001, 0, 0, 0), 8'h11, 8'hEE, 8'hEE); m[0] = 8'h11;
    step(mk(0, 0, 7'b0000010, 0, 0, 0), 8'h22, 8'hEE, 8'hEE); m[1] = 8'h22;
    step(mk(0, 0, 7'b0000100, 0, 0, 0), 8'h33, 8'hEE, 8'hEE); m[2] = 8'h33;
    step(mk(0, 0, 7'b0001000, 0, 0, 0), 8'hE1, 8'hEE, 8'h66); m[3] = 8'h66; // R6
    step(mk(0, 0, 7'b0010000, 0, 0, 0), 8'h44, 8'hEE, 8'hEE); m[4] = 8'h44;
    step(mk(0, 0, 7'b0100000, 0, 0, 0), 8'h55, 8'hEE, 8'hEE); m[5] = 8'h55;
    step(mk(0, 0, 7'b1000000, 0, 0, 0), 8'h77, 8'hEE, 8'hEE); m[6] = 8'h77; // R7 C-bus
    // R2: A codes; R3: B codes; R5: nothing else disturbed
    for (int i = 0; i < 7; i++) read_reg(i, 2);

    // R3: B field independent of A field
    step(mk(1, 7, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    push(3, K_A, m[0]); push(3, K_B, m[6]); check();
    // R4: code zero on both buses
    step(mk(0, 0, 7'd0, 0, 0, 0), 8'hFF, 8'hFF, 8'hFF);
    push(4, K_A, 8'h00); push(4, K_B, 8'h00); check();

    // R5: a load into SP alone leaves TOS unchanged
    step(mk(0, 0, 7'b0000100, 0, 0, 0), 8'h3A, 8'h00, 8'h00); m[2] = 8'h3A;
    read_reg(2, 5); read_reg(1, 5);

    // R7: data value register from RAM ignores the C bus
    step(mk(0, 0, 7'b1000000, 1, 0, 0), 8'h99, 8'h5A, 8'h00); m[6] = 8'h5A;
    read_reg(6, 7);

    // R8: write strobe and data
    step(mk(0, 0, 7'd0, 0, 1, 0), 8'h00, 8'h00, 8'h00);
    push(8, K_WE, 8'h01); push(8, K_WD, m[6]); check();
    step(mk(0, 0, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    push(8, K_WE, 8'h00); check();

    // R9: address regions and wrap
    stack_base = 8'h30;
    step(mk(0, 0, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    push(9, K_ADDR, 8'h55); check();
    step(mk(0, 0, 7'd0, 0, 0, 1), 8'h00, 8'h00, 8'h00);
    push(9, K_ADDR, 8'h85); check();
    step(mk(0, 0, 7'b0100000, 0, 0, 0), 8'hF0, 8'h00, 8'h00); m[5] = 8'hF0;
    step(mk(0, 0, 7'd0, 0, 0, 1), 8'h00, 8'h00, 8'h00);
    push(9, K_ADDR, 8'h20); check();

    // R10: ROM address follows the program counter
    push(10, K_ROM, m[4]); check();
    step(mk(0, 0, 7'b0010000, 0, 0, 0), 8'h45, 8'h00, 8'h00); m[4] = 8'h45;
    step(mk(0, 0, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    push(10, K_ROM, 8'h45); check();

    // R11: scratch on both buses while it loads
    step(mk(1, 1, 7'b0000001, 0, 0, 0), 8'h12, 8'h00, 8'h00);
    push(11, K_A, m[0]); push(11, K_B, m[0]); check();
    m[0] = 8'h12;
    read_reg(0, 11);
    // R11: write of old data value while it reloads from RAM
    step(mk(0, 0, 7'b1000000, 1, 1, 0), 8'h00, 8'hA7, 8'h00);
    push(11, K_WE, 8'h01); push(11, K_WD, m[6]); check();
    m[6] = 8'hA7;
    step(mk(0, 0, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    push(11, K_WD, 8'hA7); check();

    // R1: reset asserted mid-run clears at once
    step(mk(1, 7, 7'd0, 0, 0, 0), 8'h00, 8'h00, 8'h00);
    rst_n = 1'b0;
    #1;
    push(1, K_A, 8'h00); push(1, K_B, 8'h00); push(1, K_ROM, 8'h00); check();
    @(negedge clk); rst_n = 1'b1;
    // R1: load in the first cycle after release is blocked by the synchroniser
    step(mk(0, 0, 7'b0000001, 0, 0, 0), 8'h5E, 8'h00, 8'h00);
    for (int i = 0; i < 7; i++) m[i] = 8'h00;
    read_reg(0, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule